// File: doc/BRIEF.md
# Relative Jump Condition and Next-PC Unit

This block decides program flow for a 16-bit processor whose jumps are relative to the program counter. A decoded instruction supplies a 3-bit condition selector, a signed offset counted in words, and a flag that marks it as a jump. The current status flags (carry, zero, negative, overflow) and the current program counter are also inputs. The block says whether the jump is taken and returns the program counter for the next fetch.

The program counter is a byte address and always points at the next instruction to fetch. Instruction words are two bytes apart. Every instruction is one to three words long, counting its extension words. The block also returns the sequential address, which is the current PC advanced past the whole instruction. When the jump is not taken, or the instruction is not a jump, that sequential address becomes the next PC. The block is purely combinational. It sits between the decode stage and the PC register.

Top module: `branch_pc_unit`

## Requirements
- R1: Selector 0 (not-equal) is met when the zero flag is 0. Selector 1 (equal) is met when the zero flag is 1.
- R2: Selector 2 (no-carry) is met when carry is 0. Selector 3 (carry) is met when carry is 1.
- R3: Selector 4 (negative) is met when the negative flag is 1.
- R4: Selector 5 (signed greater-or-equal) is met when negative equals overflow. Selector 6 (signed less-than) is met when they differ.
- R5: Selector 7 (always) is met whatever the four flags hold.
- R6: When `is_jump` is 0, `take` is 0 for every selector and flag value, and `next_pc` equals `seq_pc`.
- R7: A taken jump gives `next_pc` = (aligned PC + 2 + 2 × sign-extended 10-bit offset) modulo 2^16. Both offset extremes (+511 and −512) are reached, and the sum wraps around the address space.
- R8: `seq_pc` is the aligned PC plus 2 × `len_words`, modulo 2^16. A `len_words` value of 0 is treated as 1. When no jump is taken, `next_pc` equals `seq_pc`.
- R9: The PC is aligned by forcing bit 0 of the input PC to 0 before any arithmetic. Bit 0 of `next_pc` and of `seq_pc` is always 0.
- R10: `seq_pc` keeps the sequential value while a jump is taken, so it can be used as a link or fall-through address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond | input | 3 | Condition selector, encodings 0..7 as in R1–R5 |
| is_jump | input | 1 | Current instruction is a relative jump |
| offset | input | 10 | Signed jump distance in words |
| pc | input | 16 | Current program counter (byte address) |
| len_words | input | 2 | Instruction length in words, 1..3 (0 treated as 1) |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| take | output | 1 | Jump is taken |
| next_pc | output | 16 | Program counter for the next fetch |
| seq_pc | output | 16 | Sequential address past the current instruction |

## Verification
The bench walks every selector through all sixteen flag combinations. A swapped encoding, or a signed test that looks only at the negative flag, would then take or skip jumps in the wrong cases. It drives the offset extremes and a PC near the top of memory. A design that zero-extended the offset, left out the one-word increment, or mishandled the wrap would produce a wrong target. An odd input PC and a zero length are also applied, to catch a design that passes bit 0 through or advances by nothing. A non-jump with the always selector checks that `is_jump` gates the decision.

// File: rtl/branch_pc_unit.sv
module branch_pc_unit #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 10,
  parameter int LEN_W = 2
) (
  input  logic [2:0]       cond,
  input  logic             is_jump,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len_words,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_v,
  output logic             take,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  seq_pc
);
  localparam int SEXT_W = PC_W - OFS_W - 1;

  typedef enum logic [2:0] {
    JC_NE = 3'd0, JC_EQ = 3'd1, JC_NC = 3'd2, JC_CS = 3'd3,
    JC_MI = 3'd4, JC_GE = 3'd5, JC_LT = 3'd6, JC_AL = 3'd7
  } jcond_e;

  logic [PC_W-1:0]  pc_al;
  logic [LEN_W-1:0] len_eff;
  logic [PC_W-1:0]  ofs_bytes;
  logic [PC_W-1:0]  target;
  logic             cond_met;

  assign pc_al     = {pc[PC_W-1:1], 1'b0};
  assign len_eff   = (len_words == '0) ? LEN_W'(1) : len_words;
  assign seq_pc    = pc_al + PC_W'({len_eff, 1'b0});
  assign ofs_bytes = {{SEXT_W{offset[OFS_W-1]}}, offset, 1'b0};
  assign target    = pc_al + PC_W'(2) + ofs_bytes;

  always_comb begin
    case (jcond_e'(cond))
      JC_NE:   cond_met = ~flag_z;
      JC_EQ:   cond_met = flag_z;
      JC_NC:   cond_met = ~flag_c;
      JC_CS:   cond_met = flag_c;
      JC_MI:   cond_met = flag_n;
      JC_GE:   cond_met = ~(flag_n ^ flag_v);
      JC_LT:   cond_met = flag_n ^ flag_v;
      default: cond_met = 1'b1;
    endcase
  end

  assign take    = is_jump & cond_met;
  assign next_pc = take ? target : seq_pc;
endmodule

// File: rtl/branch_pc_unit_chk.sv
module branch_pc_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 10,
  parameter int LEN_W = 2
) (
  input logic [2:0]       cond,
  input logic             is_jump,
  input logic [OFS_W-1:0] offset,
  input logic [PC_W-1:0]  pc,
  input logic [LEN_W-1:0] len_words,
  input logic             flag_c,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_v,
  input logic             take,
  input logic [PC_W-1:0]  next_pc,
  input logic [PC_W-1:0]  seq_pc
);
  always_comb begin
    if (!$isunknown({cond, is_jump, offset, pc, len_words, flag_c, flag_z, flag_n, flag_v})) begin
      a_r9_even_pc: assert (next_pc[0] == 1'b0 && seq_pc[0] == 1'b0);
      a_r6_gate: assert (is_jump || !take);
      a_r5_always: assert (!(is_jump && cond == 3'd7) || take);
      a_r8_fallthrough: assert (take || next_pc == seq_pc);
      a_r4_signed_ge: assert (!(is_jump && cond == 3'd5) || take == (flag_n == flag_v));
      a_r1_equal: assert (!(is_jump && cond == 3'd1) || take == flag_z);
    end
  end
endmodule

bind branch_pc_unit branch_pc_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_chk (
  .cond(cond), .is_jump(is_jump), .offset(offset), .pc(pc), .len_words(len_words),
  .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
  .take(take), .next_pc(next_pc), .seq_pc(seq_pc)
);

// File: tb/tb_branch_pc_unit.sv
module tb_branch_pc_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  cond = '0;
  logic        is_jump = 1'b0;
  logic [9:0]  offset = '0;
  logic [15:0] pc = '0;
  logic [1:0]  len_words = '0;
  logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
  logic        take;
  logic [15:0] next_pc, seq_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  branch_pc_unit dut (
    .cond(cond), .is_jump(is_jump), .offset(offset), .pc(pc), .len_words(len_words),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .take(take), .next_pc(next_pc), .seq_pc(seq_pc)
  );

  function automatic bit model_met(int c, bit fc, bit fz, bit fn, bit fv);
    case (c)
      0: return !fz;
      1: return fz;
      2: return !fc;
      3: return fc;
      4: return fn;
      5: return fn == fv;
      6: return fn != fv;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int c, bit j, int ofs, int p, int len, bit fc, bit fz, bit fn, bit fv, string tag);
    int base, l, o, exp_seq, exp_tgt, exp_next;
    bit exp_take;
    @(negedge clk);
    cond = c[2:0]; is_jump = j; offset = ofs[9:0]; pc = p[15:0]; len_words = len[1:0];
    flag_c = fc; flag_z = fz; flag_n = fn; flag_v = fv;
    base = p & 'hFFFE;
    l = (len == 0) ? 1 : len;
    o = ofs & 'h3FF;
    if (o >= 512) o -= 1024;
    exp_seq = (base + 2 * l) & 'hFFFF;
    exp_tgt = (base + 2 + 2 * o) & 'hFFFF;
    exp_take = j && model_met(c, fc, fz, fn, fv);
    exp_next = exp_take ? exp_tgt : exp_seq;
    #2;
    check(tag, "take", int'(take), int'(exp_take));
    check(tag, "next_pc", int'(next_pc), exp_next);
    check(tag, "seq_pc", int'(seq_pc), exp_seq);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tags [8] = '{"R1", "R1", "R2", "R2", "R3", "R4", "R4", "R5"};
    // R6: idle inputs after start, no jump
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        apply(c, 1, 5, 'h4000, 1, f[0], f[1], f[2], f[3], tags[c]);
    // R6: always selector without jump flag
    apply(7, 0, 20, 'h1000, 2, 1, 1, 1, 1, "R6");
    // R7: offset extremes and wrap
    apply(7, 1, 511, 'h8000, 1, 0, 0, 0, 0, "R7");
    apply(7, 1, 'h200, 'h8000, 1, 0, 0, 0, 0, "R7");
    apply(7, 1, 1, 'hFFFE, 1, 0, 0, 0, 0, "R7");
    apply(7, 1, 'h3FF, 'h0000, 1, 0, 0, 0, 0, "R7");
    apply(7, 1, 'h3FF, 'h0002, 1, 0, 0, 0, 0, "R7");
    // R8: each length, not taken
    for (int l = 0; l < 4; l++)
      apply(1, 1, 9, 'hFFFA, l, 0, 0, 0, 0, "R8");
    // R9: odd PC
    apply(7, 1, 3, 'h1235, 1, 0, 0, 0, 0, "R9");
    apply(0, 1, 3, 'h1235, 3, 0, 1, 0, 0, "R9");
    // R10: sequential value while taken
    apply(3, 1, 'h100, 'h2000, 3, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom);
      apply(r & 7, r[3], int'($urandom) & 'h3FF, int'($urandom) & 'hFFFF, (r >> 4) & 3,
            r[6], r[7], r[8], r[9], "R7");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule